// File: doc/BRIEF.md
# Four-Channel Configurable PWM and Capture Timer

The block holds four timer units that run independently of each other. Each unit owns one 16-bit counter, fed through its own 8-bit clock divider. A mode field selects how the counter is used. In split mode its two bytes are two separate 8-bit PWM channels. In wide mode the whole counter drives one 16-bit PWM channel. In capture mode the counter runs freely and two input pins can latch its value.

Software configures the units through a small synchronous register bus. Writes take effect on the clock edge. Reads are combinational from the address. Period and duty values are written to staged copies, and the counter hardware adopts them only when the half that uses them wraps. Waveforms therefore never carry a partial period. Each unit raises one interrupt line while any of its event flags is set.

Top module: `quad_pwm_capture_timer`

## Requirements
- R1: bus_addr[4:3] selects the unit and bus_addr[2:0] selects the register. Register 0 is control: bits 1:0 mode, bit 2 falling-edge select for capture A, bit 3 falling-edge select for capture B, bits 15:8 divider. The other registers are: 1 period, 2 duty A, 3 duty B, 4 capture A, 5 capture B, 6 flags, 7 live count. A write with bus_wr high to one unit leaves the other units unchanged.
- R2: With divider value D, a running counter advances exactly once every D+1 clocks. D=0 advances it on every clock.
- R3: Mode 1 (split) treats the two bytes separately. The low byte counts 0..period[7:0] and then returns to 0, and pwm_a is high while it is below dutyA[7:0]. The high byte does the same against period[15:8], and pwm_b is high while it is below dutyB[7:0].
- R4: Mode 2 (wide) counts 0..period and then returns to 0. pwm_a is high while the count is below dutyA, and pwm_b stays low.
- R5: Period and duty writes read back at once but reach the counter only at a wrap. The low period byte and duty A load when the low half wraps, or when the whole counter wraps in wide mode. The high period byte and duty B load when the high half wraps. Both load in any cycle where the unit is off or its mode changes.
- R6: In mode 3 (capture) the counter counts up freely. Its step from 0xFFFF to 0 sets flag bit 2.
- R7: In mode 3, a selected edge on cap_a (or cap_b) copies into capture register A (or B) the count held in the cycle the edge is seen. The same edge sets flag bit 0 (or bit 1). Rising is selected when the select bit is 0, falling when it is 1.
- R8: Writing flags clears each bit written as 1. A flag set in the same cycle wins over its clear. irq[u] is high exactly while any flag of unit u is set.
- R9: Mode 0 holds the count and divider at 0 and both PWM outputs low. Any mode change restarts the count from 0. Capture edges are ignored outside mode 3.
- R10: After reset every register reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Unit index (4:3) and register index (2:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cap_a | input | 4 | Capture input A, one per unit |
| cap_b | input | 4 | Capture input B, one per unit |
| pwm_a | output | 4 | PWM output A, one per unit |
| pwm_b | output | 4 | PWM output B, one per unit |
| irq | output | 4 | Per-unit interrupt, OR of its flags |

## Verification
The bench builds the block with its default parameters: four units, a 16-bit counter and an 8-bit divider. With these values every unit can run a different mode at the same time. A full 16-bit capture rollover is reached in about 65,536 clocks at divider 0. Divider values 1 and 3 show that the split halves and the wide counter step at the divided rate. A behavioural model advances on every clock and is compared each cycle with both PWM outputs and irq. Timed bus writes and pin edges hit the wrap-load, set-over-clear and ignored-edge cases.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_WIDE  = 2'd2,
    MODE_CAPT  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_PER   = 3'd1;
  localparam logic [2:0] RG_DUTYA = 3'd2;
  localparam logic [2:0] RG_DUTYB = 3'd3;
  localparam logic [2:0] RG_CAPA  = 3'd4;
  localparam logic [2:0] RG_CAPB  = 3'd5;
  localparam logic [2:0] RG_FLAGS = 3'd6;
  localparam logic [2:0] RG_COUNT = 3'd7;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/qtmr_prescaler.sv
module qtmr_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);

  logic [PRESC_W-1:0] pcnt;

  assign tick = run && (pcnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            pcnt <= '0;
    else if (!run || tick) pcnt <= '0;
    else                   pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/qtmr_core.sv
module qtmr_core
  import qtmr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              tick,
  input  logic [CNT_W-1:0]  per_stg,
  input  logic [CNT_W-1:0]  da_stg,
  input  logic [HALF_W-1:0] db_stg,
  output logic              restart,
  output logic              ovf_evt,
  output logic [CNT_W-1:0]  cnt,
  output logic              out_a,
  output logic              out_b
);

  function automatic logic [HALF_W-1:0] half_step(input logic [HALF_W-1:0] c,
                                                  input logic [HALF_W-1:0] lim);
    return (c == lim) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] full_step(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] lim);
    return (c == lim) ? '0 : c + 1'b1;
  endfunction

  tmr_mode_e         mode_q;
  logic              mode_chg;
  logic [CNT_W-1:0]  per_act;
  logic [CNT_W-1:0]  da_act;
  logic [HALF_W-1:0] db_act;
  logic [CNT_W-1:0]  cnt_nx;
  logic              wrap_lo, wrap_hi, load_lo, load_hi;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;

  assign cnt_lo   = cnt[HALF_W-1:0];
  assign cnt_hi   = cnt[CNT_W-1:HALF_W];
  assign mode_chg = (mode != mode_q);
  assign restart  = (mode == MODE_OFF) || mode_chg;

  always_comb begin
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    ovf_evt = 1'b0;
    cnt_nx  = cnt;
    if (restart) begin
      cnt_nx = '0;
    end else if (tick) begin
      case (mode)
        MODE_WIDE: begin
          wrap_lo = (cnt == per_act);
          wrap_hi = wrap_lo;
          cnt_nx  = full_step(cnt, per_act);
        end
        MODE_SPLIT: begin
          wrap_lo = (cnt_lo == per_act[HALF_W-1:0]);
          wrap_hi = (cnt_hi == per_act[CNT_W-1:HALF_W]);
          cnt_nx  = {half_step(cnt_hi, per_act[CNT_W-1:HALF_W]),
                     half_step(cnt_lo, per_act[HALF_W-1:0])};
        end
        MODE_CAPT: begin
          ovf_evt = &cnt;
          cnt_nx  = cnt + 1'b1;
        end
        default: ;
      endcase
    end
    load_lo = restart || wrap_lo;
    load_hi = restart || wrap_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      cnt     <= '0;
      per_act <= '0;
      da_act  <= '0;
      db_act  <= '0;
    end else begin
      mode_q <= mode;
      cnt    <= cnt_nx;
      if (load_lo) begin
        per_act[HALF_W-1:0] <= per_stg[HALF_W-1:0];
        da_act              <= da_stg;
      end
      if (load_hi) begin
        per_act[CNT_W-1:HALF_W] <= per_stg[CNT_W-1:HALF_W];
        db_act                  <= db_stg;
      end
    end
  end

  always_comb begin
    out_a = 1'b0;
    out_b = 1'b0;
    case (mode)
      MODE_WIDE:  out_a = (cnt < da_act);
      MODE_SPLIT: begin
        out_a = (cnt_lo < da_act[HALF_W-1:0]);
        out_b = (cnt_hi < db_act);
      end
      default: ;
    endcase
  end

  // R2: between divider ticks a running counter does not move
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> (cnt == $past(cnt)))
    else $error("counter moved without a divider tick");

  // R4: wide count never passes the active period
  assert_wide_within_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDE && !mode_chg) |-> (cnt <= per_act))
    else $error("wide count beyond period");

  // R5: active period held unless a wrap or restart happens
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDE && !restart && !(tick && cnt == per_act)) |=> $stable(per_act))
    else $error("period changed away from wrap");

  // R6: rollover returns the counter to zero
  assert_rollover_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0))
    else $error("rollover did not reach zero");

  // R9: an off unit holds a zero count
  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> (cnt == '0))
    else $error("off unit count not zero");

endmodule

// File: rtl/qtmr_capture.sv
module qtmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             fall_sel,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic             evt,
  output logic [CNT_W-1:0] cap_q
);

  logic pin_q;
  logic rise_seen, fall_seen;

  assign rise_seen = pin && !pin_q;
  assign fall_seen = !pin && pin_q;
  assign evt       = enable && (fall_sel ? fall_seen : rise_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cap_q <= '0;
    end else begin
      pin_q <= pin;
      if (evt) cap_q <= cnt;
    end
  end

  // R7: the stored value is the count of the edge cycle
  assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_q == $past(cnt)))
    else $error("captured value mismatch");

endmodule

// File: rtl/qtmr_unit.sv
module qtmr_unit
  import qtmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 8,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       reg_sel,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             cap_a,
  input  logic             cap_b,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             irq
);

  tmr_mode_e          mode_r;
  logic               fall_a, fall_b;
  logic [PRESC_W-1:0] presc_r;
  logic [CNT_W-1:0]   per_stg, da_stg, db_stg;
  logic [FLAG_W-1:0]  flags, flag_set, flag_clr;
  logic [CNT_W-1:0]   cnt, cap_a_q, cap_b_q, ctrl_rd;
  logic               tick, restart, ovf_evt, evt_a, evt_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r  <= MODE_OFF;
      fall_a  <= 1'b0;
      fall_b  <= 1'b0;
      presc_r <= '0;
      per_stg <= '0;
      da_stg  <= '0;
      db_stg  <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        RG_CTRL: begin
          mode_r  <= tmr_mode_e'(wdata[1:0]);
          fall_a  <= wdata[2];
          fall_b  <= wdata[3];
          presc_r <= wdata[8 +: PRESC_W];
        end
        RG_PER:   per_stg <= wdata;
        RG_DUTYA: da_stg  <= wdata;
        RG_DUTYB: db_stg  <= wdata;
        default: ;
      endcase
    end
  end

  qtmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!restart),
    .div  (presc_r),
    .tick (tick)
  );

  qtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_r),
    .tick   (tick),
    .per_stg(per_stg),
    .da_stg (da_stg),
    .db_stg (db_stg[HALF_W-1:0]),
    .restart(restart),
    .ovf_evt(ovf_evt),
    .cnt    (cnt),
    .out_a  (pwm_a),
    .out_b  (pwm_b)
  );

  qtmr_capture #(.CNT_W(CNT_W)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .enable(mode_r == MODE_CAPT), .fall_sel(fall_a),
    .pin(cap_a), .cnt(cnt), .evt(evt_a), .cap_q(cap_a_q)
  );

  qtmr_capture #(.CNT_W(CNT_W)) u_cap_b (
    .clk(clk), .rst_n(rst_n), .enable(mode_r == MODE_CAPT), .fall_sel(fall_b),
    .pin(cap_b), .cnt(cnt), .evt(evt_b), .cap_q(cap_b_q)
  );

  assign flag_set = {ovf_evt, evt_b, evt_a};
  assign flag_clr = (wr_en && reg_sel == RG_FLAGS) ? wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  assign irq = |flags;

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[1:0]             = mode_r;
    ctrl_rd[2]               = fall_a;
    ctrl_rd[3]               = fall_b;
    ctrl_rd[8 +: PRESC_W]    = presc_r;
  end

  always_comb begin
    case (reg_sel)
      RG_CTRL:  rdata = ctrl_rd;
      RG_PER:   rdata = per_stg;
      RG_DUTYA: rdata = da_stg;
      RG_DUTYB: rdata = db_stg;
      RG_CAPA:  rdata = cap_a_q;
      RG_CAPB:  rdata = cap_b_q;
      RG_FLAGS: rdata = CNT_W'(flags);
      default:  rdata = cnt;
    endcase
  end

  // R8: a raised event is visible in the flags on the next cycle, clear or not
  assert_flag_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags & $past(flag_set)) == $past(flag_set)))
    else $error("event flag lost");

  // R9: capture edges cannot happen outside capture mode
  assert_no_capture_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r != MODE_CAPT) |-> !(evt_a || evt_b))
    else $error("capture event outside capture mode");

endmodule

// File: rtl/quad_pwm_capture_timer.sv
module quad_pwm_capture_timer #(
  parameter int NUM_UNITS = 4,
  parameter int CNT_W     = 16,
  parameter int PRESC_W   = 8,
  parameter int ADDR_W    = $clog2(NUM_UNITS) + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  input  logic [NUM_UNITS-1:0] cap_a,
  input  logic [NUM_UNITS-1:0] cap_b,
  output logic [NUM_UNITS-1:0] pwm_a,
  output logic [NUM_UNITS-1:0] pwm_b,
  output logic [NUM_UNITS-1:0] irq
);

  localparam int UNIT_W = ADDR_W - 3;

  logic [UNIT_W-1:0] unit_idx;
  logic [2:0]        reg_sel;
  logic [CNT_W-1:0]  rd_arr [NUM_UNITS];

  assign unit_idx = bus_addr[ADDR_W-1:3];
  assign reg_sel  = bus_addr[2:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic wr_hit;
    assign wr_hit = bus_wr && (unit_idx == UNIT_W'(u));

    qtmr_unit #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_hit),
      .reg_sel(reg_sel),
      .wdata  (bus_wdata),
      .rdata  (rd_arr[u]),
      .cap_a  (cap_a[u]),
      .cap_b  (cap_b[u]),
      .pwm_a  (pwm_a[u]),
      .pwm_b  (pwm_b[u]),
      .irq    (irq[u])
    );
  end

  assign bus_rdata = rd_arr[unit_idx];

  // R1: at most one unit takes any bus write
  assert_single_unit_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_unit[3].wr_hit, g_unit[2].wr_hit, g_unit[1].wr_hit, g_unit[0].wr_hit}))
    else $error("bus write reached several units");

endmodule

// File: tb/sim_quad_pwm_capture_timer.sv
module sim_quad_pwm_capture_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_a = '0, cap_b = '0;
  logic [3:0]  pwm_a, pwm_b, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pwm_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_a(cap_a), .cap_b(cap_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  // reference model state, one entry per unit
  int m_md[4], m_mq[4], m_ea[4], m_eb[4], m_ps[4], m_pc[4], m_cnt[4];
  int m_pstg[4], m_dastg[4], m_dbstg[4], m_pact[4], m_daact[4], m_dbact[4];
  int m_capa[4], m_capb[4], m_fl[4], m_ina[4], m_inb[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < 4; u++) begin
        m_md[u] = 0; m_mq[u] = 0; m_ea[u] = 0; m_eb[u] = 0; m_ps[u] = 0; m_pc[u] = 0;
        m_cnt[u] = 0; m_pstg[u] = 0; m_dastg[u] = 0; m_dbstg[u] = 0; m_pact[u] = 0;
        m_daact[u] = 0; m_dbact[u] = 0; m_capa[u] = 0; m_capb[u] = 0; m_fl[u] = 0;
        m_ina[u] = 0; m_inb[u] = 0;
      end
    end else begin
      for (int u = 0; u < 4; u++) begin
        int md, lo, hi, setf, clr, pa, pb;
        bit restart, tick, ea, eb, ovf, ld_lo, ld_hi, hit;
        md = m_md[u];
        restart = (md == 0) || (md != m_mq[u]);
        tick = !restart && (m_pc[u] == m_ps[u]);
        m_pc[u] = (restart || tick) ? 0 : m_pc[u] + 1;
        pa = int'(cap_a[u]);
        pb = int'(cap_b[u]);
        ea = (md == 3) && ((m_ea[u] != 0) ? (m_ina[u] == 1 && pa == 0) : (m_ina[u] == 0 && pa == 1));
        eb = (md == 3) && ((m_eb[u] != 0) ? (m_inb[u] == 1 && pb == 0) : (m_inb[u] == 0 && pb == 1));
        if (ea) m_capa[u] = m_cnt[u];
        if (eb) m_capb[u] = m_cnt[u];
        ovf = 0; ld_lo = restart; ld_hi = restart;
        if (restart) m_cnt[u] = 0;
        else if (tick) begin
          if (md == 2) begin
            if (m_cnt[u] == m_pact[u]) begin m_cnt[u] = 0; ld_lo = 1; ld_hi = 1; end
            else m_cnt[u] = m_cnt[u] + 1;
          end else if (md == 1) begin
            lo = m_cnt[u] % 256; hi = m_cnt[u] / 256;
            if (lo == m_pact[u] % 256) begin lo = 0; ld_lo = 1; end else lo = lo + 1;
            if (hi == m_pact[u] / 256) begin hi = 0; ld_hi = 1; end else hi = hi + 1;
            m_cnt[u] = hi * 256 + lo;
          end else if (md == 3) begin
            if (m_cnt[u] == 65535) begin m_cnt[u] = 0; ovf = 1; end
            else m_cnt[u] = m_cnt[u] + 1;
          end
        end
        if (ld_lo) begin
          m_pact[u] = (m_pact[u] & 'hFF00) | (m_pstg[u] & 'hFF);
          m_daact[u] = m_dastg[u];
        end
        if (ld_hi) begin
          m_pact[u] = (m_pact[u] & 'hFF) | (m_pstg[u] & 'hFF00);
          m_dbact[u] = m_dbstg[u] & 'hFF;
        end
        hit = bus_wr && (int'(bus_addr[4:3]) == u);
        clr = (hit && int'(bus_addr[2:0]) == 6) ? (int'(bus_wdata) & 7) : 0;
        setf = (ovf ? 4 : 0) | (eb ? 2 : 0) | (ea ? 1 : 0);
        m_fl[u] = (m_fl[u] & ~clr) | setf;
        if (hit) begin
          case (int'(bus_addr[2:0]))
            0: begin
              m_md[u] = int'(bus_wdata[1:0]); m_ea[u] = int'(bus_wdata[2]);
              m_eb[u] = int'(bus_wdata[3]);   m_ps[u] = int'(bus_wdata[15:8]);
            end
            1: m_pstg[u]  = int'(bus_wdata);
            2: m_dastg[u] = int'(bus_wdata);
            3: m_dbstg[u] = int'(bus_wdata);
            default: ;
          endcase
        end
        m_mq[u] = md; m_ina[u] = pa; m_inb[u] = pb;
      end
    end
  end

  function automatic int exp_a(int u);
    if (m_md[u] == 2) return (m_cnt[u] < m_daact[u]) ? 1 : 0;
    if (m_md[u] == 1) return ((m_cnt[u] % 256) < (m_daact[u] % 256)) ? 1 : 0;
    return 0;
  endfunction

  function automatic int exp_b(int u);
    if (m_md[u] == 1) return ((m_cnt[u] / 256) < m_dbact[u]) ? 1 : 0;
    return 0;
  endfunction

  function automatic int mread(int u, int r);
    case (r)
      0: return m_ps[u] * 256 + m_eb[u] * 8 + m_ea[u] * 4 + m_md[u];
      1: return m_pstg[u];
      2: return m_dastg[u];
      3: return m_dbstg[u];
      4: return m_capa[u];
      5: return m_capb[u];
      6: return m_fl[u];
      default: return m_cnt[u];
    endcase
  endfunction

  function automatic string mode_tag(int u);
    if (m_md[u] == 2) return "R4";
    if (m_md[u] == 1) return "R3";
    return "R9";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison of outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int u = 0; u < 4; u++) begin
        chk(mode_tag(u), $sformatf("pwm_a[%0d]", u), int'(pwm_a[u]), exp_a(u));
        chk(mode_tag(u), $sformatf("pwm_b[%0d]", u), int'(pwm_b[u]), exp_b(u));
        chk("R8", $sformatf("irq[%0d]", u), int'(irq[u]), (m_fl[u] != 0) ? 1 : 0);
      end
    end
  end

  task automatic wr(int u, int r, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(u * 8 + r); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int u, int r, string tag);
    @(negedge clk);
    bus_addr = 5'(u * 8 + r);
    #1;
    chk(tag, $sformatf("reg u%0d r%0d", u, r), int'(bus_rdata), mread(u, r));
  endtask

  task automatic rd_lit(int u, int r, int exp, string tag);
    @(negedge clk);
    bus_addr = 5'(u * 8 + r);
    #1;
    chk(tag, $sformatf("reg u%0d r%0d", u, r), int'(bus_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R10: all registers zero, outputs low after reset
    for (int u = 0; u < 4; u++)
      for (int r = 0; r < 8; r++) rd_lit(u, r, 0, "R10");
    chk("R10", "outputs", int'({pwm_a, pwm_b, irq}), 0);

    // R4: wide mode, divider 0, period 9, duty 4
    wr(0, 1, 9); wr(0, 2, 4); wr(0, 0, 2);
    idle(37); rd(0, 7, "R4");
    // R3: split mode with divider 1, periods 3/5, duties 2/4
    wr(1, 1, 16'h0503); wr(1, 2, 2); wr(1, 3, 4); wr(1, 0, 16'h0101);
    idle(41); rd(1, 7, "R3");
    // R2: wide mode at divider 3
    wr(2, 1, 7); wr(2, 2, 3); wr(2, 0, 16'h0302);
    for (int k = 0; k < 6; k++) begin idle(3); rd(2, 7, "R2"); end
    rd(2, 0, "R1");
    rd(1, 0, "R1");
    rd(0, 1, "R1");

    // R5: staged values read back at once and apply at wrap
    wr(0, 1, 20); rd(0, 1, "R5");
    wr(0, 2, 15); rd(0, 2, "R5");
    idle(50); rd(0, 7, "R5");
    wr(1, 3, 1); rd(1, 3, "R5");
    idle(30);

    // R9: edges ignored in wide mode
    @(negedge clk); cap_a[0] = 1'b1; cap_b[0] = 1'b1;
    @(negedge clk); cap_a[0] = 1'b0; cap_b[0] = 1'b0;
    idle(2);
    rd_lit(0, 4, 0, "R9"); rd_lit(0, 5, 0, "R9"); rd_lit(0, 6, 0, "R9");

    // R7: capture unit 3, A rising, B falling
    wr(3, 0, 16'h000B);
    idle(13);
    @(negedge clk); cap_a[3] = 1'b1;
    idle(2); rd(3, 4, "R7"); rd(3, 6, "R7");
    @(negedge clk); cap_b[3] = 1'b1;
    idle(3); rd(3, 5, "R7");
    @(negedge clk); cap_b[3] = 1'b0;
    idle(2); rd(3, 5, "R7"); rd(3, 6, "R7");
    @(negedge clk); cap_a[3] = 1'b0;
    idle(2); rd(3, 4, "R7");

    // R8: write-one-to-clear
    wr(3, 6, 2); rd(3, 6, "R8");
    wr(3, 6, 1); rd(3, 6, "R8");
    // R8: set wins over simultaneous clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(3 * 8 + 6); bus_wdata = 16'd1; cap_a[3] = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(3, 6, "R8");
    @(negedge clk); bus_addr = 5'(3 * 8 + 6); #1;
    chk("R8", "set over clear", int'(bus_rdata[0]), 1);
    wr(3, 6, 7); rd(3, 6, "R8");

    // R6: full rollover sets the overflow flag
    idle(65560);
    rd(3, 6, "R6");
    @(negedge clk); bus_addr = 5'(3 * 8 + 6); #1;
    chk("R6", "overflow flag", int'(bus_rdata[2]), 1);
    rd(3, 7, "R6");

    // R9: turning a unit off
    wr(1, 0, 0); idle(3);
    rd_lit(1, 7, 0, "R9");
    // R9: mode change restarts from zero
    wr(2, 0, 16'h0301); rd(2, 7, "R9");
    idle(20); rd(2, 7, "R3");

    idle(4);
    finish_run();
  end

endmodule